// File: doc/BRIEF.md
# CPU Stack Context Sequencer

This block carries out the multi-cycle stack transfers of a small 8-bit processor core: interrupt entry, return from interrupt, subroutine call, subroutine return, and single-register push and pop. It owns an 8-bit stack pointer. The high byte of every stack address is fixed in hardware at 01H, so the stack always lies in the page 100H to 1FFH. The block drives a byte-wide data-memory port with exactly one access per clock.

The core's decoder picks a command code and raises `start` for one cycle. It also presents the current program counter, status word and push register. The sequencer copies these values when it accepts the command, then steps through the bytes of the transfer. It finishes with a one-cycle `done` pulse. At that pulse, any bytes read back from the stack are valid on `pc_out`, `psw_out` or `pop_out`.

The pointer has no defined power-on value in the programming model, so software loads it through `sp_load`, which is the register-transfer path from the X index register. The memory port reads asynchronously: `mem_rdata` must reflect `mem_addr` within the same cycle.

Top module: `stk_ctx_seq`

## Requirements
- R1: Every access drives `mem_addr[15:8]` = 01H. The low byte is SP for a write and SP+1 for a read. A write decrements SP after the access. A read increments SP before the access, in the same cycle.
- R2: Command code 0 (interrupt entry) writes PC[15:8], then PC[7:0], then the status word, to addresses SP, SP-1 and SP-2. SP ends 3 lower.
- R3: Command code 1 (interrupt return) reads the status word from SP+1, PC[7:0] from SP+2 and PC[15:8] from SP+3. The results appear on `psw_out` and `pc_out`, and SP ends 3 higher.
- R4: Command code 2 (call) writes PC[15:8] then PC[7:0], and SP ends 2 lower. Command code 3 (return) reads PC[7:0] from SP+1 and PC[15:8] from SP+2 onto `pc_out`, and SP ends 2 higher.
- R5: Command code 4 (push) writes `reg_in` at SP, and SP ends 1 lower. Command code 5 (pop) reads SP+1 onto `pop_out`, and SP ends 1 higher.
- R6: The first access happens in the cycle after `start` is accepted, and the rest follow one per cycle. `busy` is high during the access cycles. `done` is high for the single cycle after the last access, with `busy` low. A new command can be accepted in that `done` cycle.
- R7: While `busy` is high, `start` is ignored. A `start` with code 6 or 7 is ignored. An ignored command makes no access and leaves SP unchanged.
- R8: When the block is idle, `sp_load` copies `sp_load_val` into SP. A `start` in the same cycle is dropped. While `busy` is high, `sp_load` has no effect.
- R9: SP arithmetic wraps modulo 256, so stack addresses stay inside 100H to 1FFH.
- R10: After reset, `busy`, `done`, `mem_we` and `mem_re` are low and `sp_out` is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe |
| cmd | input | 3 | Command code (0..5 valid) |
| pc_in | input | 16 | Program counter to save |
| psw_in | input | 8 | Status word to save |
| reg_in | input | 8 | Register value for push |
| sp_load | input | 1 | Load stack pointer (transfer from X) |
| sp_load_val | input | 8 | New stack pointer value |
| mem_addr | output | 16 | Data-memory address |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 8 | Current stack pointer |
| pc_out | output | 16 | Restored program counter |
| psw_out | output | 8 | Restored status word |
| pop_out | output | 8 | Popped register byte |

## Verification
The bench starts with an interrupt entry followed by its return, and the status word and PC halves hold distinct values. A swapped byte order or a post-increment read then shows up as a wrong address or a wrong restored value. Nested pushes around a call and return check that the single-byte and two-byte frames interleave in last-in, first-out order. An entry and return with SP at 01H carry the addresses across 100H to 1FFH, which separates wrapping within the page from carrying into the high byte. Strobes sent while busy, reserved codes, and a load that collides with a start each check that no stray access or pointer change appears.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        CMD_IRQ  = 3'd0,
        CMD_RETI = 3'd1,
        CMD_CALL = 3'd2,
        CMD_RET  = 3'd3,
        CMD_PUSH = 3'd4,
        CMD_POP  = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } stk_cmd_e;

    // Which byte of the saved context a step moves
    typedef enum logic [1:0] {
        FLD_PCH = 2'd0,
        FLD_PCL = 2'd1,
        FLD_PSW = 2'd2,
        FLD_REG = 2'd3
    } stk_fld_e;

    typedef struct packed {
        logic     wr;    // 1: push step, 0: pop step
        stk_fld_e fld;
        logic     last;
    } stk_step_t;

    function automatic logic cmd_legal(stk_cmd_e c);
        return (c != CMD_RSV6) && (c != CMD_RSV7);
    endfunction

endpackage

// File: rtl/stk_step_decode.sv
module stk_step_decode
    import stk_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  stk_cmd_e         cmd,
    input  logic [IDX_W-1:0] idx,
    output stk_step_t        step
);

    always_comb begin
        step = '{wr: 1'b0, fld: FLD_REG, last: 1'b1};
        unique case (cmd)
            CMD_IRQ: begin
                step.wr = 1'b1;
                case (idx)
                    2'd0:    begin step.fld = FLD_PCH; step.last = 1'b0; end
                    2'd1:    begin step.fld = FLD_PCL; step.last = 1'b0; end
                    default: begin step.fld = FLD_PSW; step.last = 1'b1; end
                endcase
            end
            CMD_RETI: begin
                step.wr = 1'b0;
                case (idx)
                    2'd0:    begin step.fld = FLD_PSW; step.last = 1'b0; end
                    2'd1:    begin step.fld = FLD_PCL; step.last = 1'b0; end
                    default: begin step.fld = FLD_PCH; step.last = 1'b1; end
                endcase
            end
            CMD_CALL: begin
                step.wr = 1'b1;
                if (idx == '0) begin
                    step.fld  = FLD_PCH;
                    step.last = 1'b0;
                end else begin
                    step.fld  = FLD_PCL;
                    step.last = 1'b1;
                end
            end
            CMD_RET: begin
                step.wr = 1'b0;
                if (idx == '0) begin
                    step.fld  = FLD_PCL;
                    step.last = 1'b0;
                end else begin
                    step.fld  = FLD_PCH;
                    step.last = 1'b1;
                end
            end
            CMD_PUSH: begin
                step.wr   = 1'b1;
                step.fld  = FLD_REG;
                step.last = 1'b1;
            end
            default: begin
                step.wr   = 1'b0;
                step.fld  = FLD_REG;
                step.last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int                PTR_W  = 8,
    parameter int                PAGE_W = 8,
    parameter logic [PAGE_W-1:0] PAGE   = 8'h01,
    localparam int               ADDR_W = PAGE_W + PTR_W
) (
    input  logic [PTR_W-1:0]  sp,
    input  logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [PTR_W-1:0]  sp_nxt
);

    localparam logic [PTR_W-1:0] ONE = 1;

    logic [PTR_W-1:0] sp_inc;
    logic [PTR_W-1:0] sp_dec;

    always_comb begin
        sp_inc = sp + ONE;   // wraps within the page
        sp_dec = sp - ONE;
        if (wr) begin
            addr   = {PAGE, sp};
            sp_nxt = sp_dec;
        end else begin
            addr   = {PAGE, sp_inc};
            sp_nxt = sp_inc;
        end
    end

endmodule

// File: rtl/stk_byte_route.sv
module stk_byte_route
    import stk_pkg::*;
#(
    parameter int DW = 8
) (
    input  stk_fld_e        fld,
    input  logic            rd_en,
    input  logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   src_pch,
    input  logic [DW-1:0]   src_pcl,
    input  logic [DW-1:0]   src_psw,
    input  logic [DW-1:0]   src_reg,
    input  logic [DW-1:0]   cur_pch,
    input  logic [DW-1:0]   cur_pcl,
    input  logic [DW-1:0]   cur_psw,
    input  logic [DW-1:0]   cur_reg,
    output logic [DW-1:0]   wdata,
    output logic [DW-1:0]   nxt_pch,
    output logic [DW-1:0]   nxt_pcl,
    output logic [DW-1:0]   nxt_psw,
    output logic [DW-1:0]   nxt_reg
);

    always_comb begin
        unique case (fld)
            FLD_PCH: wdata = src_pch;
            FLD_PCL: wdata = src_pcl;
            FLD_PSW: wdata = src_psw;
            default: wdata = src_reg;
        endcase

        nxt_pch = cur_pch;
        nxt_pcl = cur_pcl;
        nxt_psw = cur_psw;
        nxt_reg = cur_reg;
        if (rd_en) begin
            unique case (fld)
                FLD_PCH: nxt_pch = rdata;
                FLD_PCL: nxt_pcl = rdata;
                FLD_PSW: nxt_psw = rdata;
                default: nxt_reg = rdata;
            endcase
        end
    end

endmodule

// File: rtl/stk_ctx_seq.sv
module stk_ctx_seq
    import stk_pkg::*;
#(
    parameter int                DW     = 8,
    parameter int                PTR_W  = 8,
    parameter int                PAGE_W = 8,
    parameter logic [PAGE_W-1:0] PAGE   = 8'h01,
    localparam int               ADDR_W = PAGE_W + PTR_W,
    localparam int               PC_W   = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DW-1:0]     psw_in,
    input  logic [DW-1:0]     reg_in,
    input  logic              sp_load,
    input  logic [PTR_W-1:0]  sp_load_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [PTR_W-1:0]  sp_out,
    output logic [PC_W-1:0]   pc_out,
    output logic [DW-1:0]     psw_out,
    output logic [DW-1:0]     pop_out
);

    localparam int IDX_W = 2;   // longest sequence is three steps

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
        stk_cmd_e         cmd;
        logic [PTR_W-1:0] sp;
        logic [DW-1:0]    s_pch;   // bytes captured at start
        logic [DW-1:0]    s_pcl;
        logic [DW-1:0]    s_psw;
        logic [DW-1:0]    s_reg;
        logic [DW-1:0]    r_pch;   // bytes restored from the stack
        logic [DW-1:0]    r_pcl;
        logic [DW-1:0]    r_psw;
        logic [DW-1:0]    r_reg;
    } seq_state_t;

    seq_state_t st_q, st_d;

    stk_step_t        step;
    logic [ADDR_W-1:0] step_addr;
    logic [PTR_W-1:0] sp_step;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    nx_pch, nx_pcl, nx_psw, nx_reg;
    stk_cmd_e         cmd_in;

    assign cmd_in = stk_cmd_e'(cmd);

    stk_step_decode #(.IDX_W(IDX_W)) u_dec (
        .cmd  (st_q.cmd),
        .idx  (st_q.idx),
        .step (step)
    );

    stk_addr_gen #(.PTR_W(PTR_W), .PAGE_W(PAGE_W), .PAGE(PAGE)) u_addr (
        .sp     (st_q.sp),
        .wr     (step.wr),
        .addr   (step_addr),
        .sp_nxt (sp_step)
    );

    stk_byte_route #(.DW(DW)) u_route (
        .fld     (step.fld),
        .rd_en   (st_q.busy && !step.wr),
        .rdata   (mem_rdata),
        .src_pch (st_q.s_pch),
        .src_pcl (st_q.s_pcl),
        .src_psw (st_q.s_psw),
        .src_reg (st_q.s_reg),
        .cur_pch (st_q.r_pch),
        .cur_pcl (st_q.r_pcl),
        .cur_psw (st_q.r_psw),
        .cur_reg (st_q.r_reg),
        .wdata   (wdata),
        .nxt_pch (nx_pch),
        .nxt_pcl (nx_pcl),
        .nxt_psw (nx_psw),
        .nxt_reg (nx_reg)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.sp    = sp_step;
            st_d.r_pch = nx_pch;
            st_d.r_pcl = nx_pcl;
            st_d.r_psw = nx_psw;
            st_d.r_reg = nx_reg;
            if (step.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (sp_load) begin
            st_d.sp = sp_load_val;          // load wins over a start
        end else if (start && cmd_legal(cmd_in)) begin
            st_d.busy  = 1'b1;
            st_d.cmd   = cmd_in;
            st_d.idx   = '0;
            st_d.s_pch = pc_in[PC_W-1:DW];
            st_d.s_pcl = pc_in[DW-1:0];
            st_d.s_psw = psw_in;
            st_d.s_reg = reg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, idx: '0, cmd: CMD_IRQ, sp: '0,
                      s_pch: '0, s_pcl: '0, s_psw: '0, s_reg: '0,
                      r_pch: '0, r_pcl: '0, r_psw: '0, r_reg: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = step_addr;
    assign mem_we    = st_q.busy && step.wr;
    assign mem_re    = st_q.busy && !step.wr;
    assign mem_wdata = wdata;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign sp_out    = st_q.sp;
    assign pc_out    = {st_q.r_pch, st_q.r_pcl};
    assign psw_out   = st_q.r_psw;
    assign pop_out   = st_q.r_reg;

endmodule

// File: rtl/stk_ctx_seq_chk.sv
module stk_ctx_seq_chk #(
    parameter int                PTR_W  = 8,
    parameter int                PAGE_W = 8,
    parameter logic [PAGE_W-1:0] PAGE   = 8'h01,
    localparam int               ADDR_W = PAGE_W + PTR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              busy,
    input logic              done,
    input logic [PTR_W-1:0]  sp_out,
    input logic              sp_load,
    input logic [PTR_W-1:0]  sp_load_val
);

    localparam logic [PTR_W-1:0] ONE = 1;

    logic [PTR_W-1:0] sp_m1, sp_p1;
    assign sp_m1 = sp_out - ONE;
    assign sp_p1 = sp_out + ONE;

    a_r1_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> mem_addr[ADDR_W-1:PTR_W] == PAGE);

    a_r1_push_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[PTR_W-1:0] == sp_out);

    a_r1_pop_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr[PTR_W-1:0] == sp_p1);

    a_r9_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(sp_m1));

    a_r9_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_out == $past(sp_p1));

    a_r6_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sp_load) |=> (sp_out == $past(sp_load_val) && !busy));

endmodule

bind stk_ctx_seq stk_ctx_seq_chk #(
    .PTR_W(PTR_W), .PAGE_W(PAGE_W), .PAGE(PAGE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .busy(busy), .done(done), .sp_out(sp_out),
    .sp_load(sp_load), .sp_load_val(sp_load_val)
);

// File: tb/tb_stk_ctx_seq.sv
`timescale 1ns/1ps
module tb_stk_ctx_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cmd = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  psw_in = '0, reg_in = '0;
    logic        sp_load = 1'b0;
    logic [7:0]  sp_load_val = '0;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done;
    logic [7:0]  sp_out, psw_out, pop_out;
    logic [15:0] pc_out;

    always #2.5 clk = ~clk;

    stk_ctx_seq dut (.*);

    // bench RAM, asynchronous read
    logic [7:0] ram [512];
    assign mem_rdata = ram[mem_addr[8:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[8:0]] <= mem_wdata;

    typedef struct packed { logic wr; logic [15:0] addr; logic [7:0] data; } acc_t;
    acc_t  exp_q [$];
    string tag_q [$];

    int total = 0, bad = 0;
    bit finished = 0;

    // independent model
    logic [7:0]  m_sp = 8'h00;
    logic [7:0]  m_mem [512];
    logic [15:0] m_pc = '0;
    logic [7:0]  m_psw = '0, m_pop = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic push_w(input logic [7:0] d, input string tag);
        exp_q.push_back('{wr: 1'b1, addr: {8'h01, m_sp}, data: d});
        tag_q.push_back(tag);
        m_mem[{1'b1, m_sp}] = d;
        m_sp = m_sp - 8'd1;
    endtask

    task automatic pop_r(output logic [7:0] d, input string tag);
        m_sp = m_sp + 8'd1;
        exp_q.push_back('{wr: 1'b0, addr: {8'h01, m_sp}, data: 8'h00});
        tag_q.push_back(tag);
        d = m_mem[{1'b1, m_sp}];
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (mem_we || mem_re)) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected access", {15'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                acc_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " access kind"}, {31'd0, mem_we}, {31'd0, e.wr});
                chk({t, " address"}, {16'd0, mem_addr}, {16'd0, e.addr});
                if (e.wr) chk({t, " write data"}, {24'd0, mem_wdata}, {24'd0, e.data});
            end
        end
    end

    // driver: poke=1 sends a stray start (push) and a stray sp_load during busy
    task automatic run_cmd(input logic [2:0] c, input logic [15:0] pcv,
                           input logic [7:0] pswv, input logic [7:0] rv,
                           input string tag, input bit poke);
        logic [7:0] b0, b1, b2;
        int n;
        case (c)
            3'd0: begin push_w(pcv[15:8], tag); push_w(pcv[7:0], tag); push_w(pswv, tag); end
            3'd1: begin pop_r(b0, tag); pop_r(b1, tag); pop_r(b2, tag); m_psw = b0; m_pc = {b2, b1}; end
            3'd2: begin push_w(pcv[15:8], tag); push_w(pcv[7:0], tag); end
            3'd3: begin pop_r(b0, tag); pop_r(b1, tag); m_pc = {b1, b0}; end
            3'd4: push_w(rv, tag);
            default: begin pop_r(b0, tag); m_pop = b0; end
        endcase
        @(negedge clk);
        cmd = c; pc_in = pcv; psw_in = pswv; reg_in = rv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R6 busy after start"}, {31'd0, busy}, 32'd1);
        if (poke) begin
            start = 1'b1; cmd = 3'd4; reg_in = 8'hEE;
            sp_load = 1'b1; sp_load_val = 8'h80;
            @(negedge clk);
            start = 1'b0; sp_load = 1'b0;
        end
        n = 0;
        while (!done && n < 20) begin @(negedge clk); n++; end
        chk({tag, " R6 done seen"}, {31'd0, done}, 32'd1);
        chk({tag, " R6 busy low at done"}, {31'd0, busy}, 32'd0);
        chk({tag, " R9 sp after"}, {24'd0, sp_out}, {24'd0, m_sp});
        chk({tag, " R7 queue drained"}, exp_q.size(), 32'd0);
        if (c == 3'd1) chk({tag, " R3 psw restored"}, {24'd0, psw_out}, {24'd0, m_psw});
        if (c == 3'd1 || c == 3'd3) chk({tag, " pc restored"}, {16'd0, pc_out}, {16'd0, m_pc});
        if (c == 3'd5) chk({tag, " R5 pop value"}, {24'd0, pop_out}, {24'd0, m_pop});
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, {31'd0, done}, 32'd0);
    endtask

    task automatic load_sp(input logic [7:0] v);
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
        m_sp = v;
        chk("R8 sp load", {24'd0, sp_out}, {24'd0, v});
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin ram[i] = 8'h00; m_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 done", {31'd0, done}, 32'd0);
        chk("R10 no access", {30'd0, mem_we, mem_re}, 32'd0);
        chk("R10 sp", {24'd0, sp_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        load_sp(8'h3F);
        // R2 / R3 interrupt frame and its return
        run_cmd(3'd0, 16'h1234, 8'hA5, 8'h00, "R2 irq", 1'b0);
        run_cmd(3'd1, 16'h0000, 8'h00, 8'h00, "R3 reti", 1'b0);
        // R4 / R5 nesting of pushes around a call
        run_cmd(3'd4, 16'h0000, 8'h00, 8'h11, "R5 push a", 1'b0);
        run_cmd(3'd4, 16'h0000, 8'h00, 8'h22, "R5 push b", 1'b0);
        run_cmd(3'd2, 16'hBEEF, 8'h00, 8'h00, "R4 call", 1'b0);
        run_cmd(3'd3, 16'h0000, 8'h00, 8'h00, "R4 ret", 1'b0);
        run_cmd(3'd5, 16'h0000, 8'h00, 8'h00, "R5 pop b", 1'b0);
        run_cmd(3'd5, 16'h0000, 8'h00, 8'h00, "R5 pop a", 1'b0);
        // R9 wrap across 100H/1FFH
        load_sp(8'h01);
        run_cmd(3'd0, 16'hC3D4, 8'h5A, 8'h00, "R9 irq wrap", 1'b0);
        chk("R9 wrap sp", {24'd0, sp_out}, 32'h0000_00FE);
        run_cmd(3'd1, 16'h0000, 8'h00, 8'h00, "R9 reti wrap", 1'b0);
        // R7/R8 stray start and load while busy
        load_sp(8'h20);
        run_cmd(3'd0, 16'h7788, 8'h99, 8'h00, "R7 irq poked", 1'b1);
        run_cmd(3'd1, 16'h0000, 8'h00, 8'h00, "R8 reti after poke", 1'b0);
        // R7 reserved codes
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            cmd = 3'(k); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R7 reserved busy", {31'd0, busy}, 32'd0);
            @(negedge clk);
            chk("R7 reserved done", {31'd0, done}, 32'd0);
            chk("R7 reserved sp", {24'd0, sp_out}, {24'd0, m_sp});
        end
        // R8 load collides with start
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = 8'h40; start = 1'b1; cmd = 3'd4;
        @(negedge clk);
        sp_load = 1'b0; start = 1'b0;
        m_sp = 8'h40;
        chk("R8 load beats start busy", {31'd0, busy}, 32'd0);
        chk("R8 load beats start sp", {24'd0, sp_out}, 32'h0000_0040);
        repeat (2) @(negedge clk);
        chk("R8 no later access", {31'd0, busy}, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog R6 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule